// File: doc/BRIEF.md
# Dual-Word SECDED Flash Protector

This block protects program-memory contents that are stored as pairs of 24-bit instruction words. On the write side it takes the 48 data bits of a pair and produces a 7-bit check code, which the memory stores next to the data as a 55-bit word. On the read side it takes the stored 55-bit word, recomputes the code, and returns corrected data one clock later. Protection is always active: there is no bypass. The check bits never appear on the data output.

A single flipped bit anywhere in the stored word is located and repaired, and a one-cycle single-error flag is raised. That flag is forwarded to an interrupt pulse only while the interrupt enable input is high. When two bits are flipped, the data is passed through unrepaired and a one-cycle double-error flag is raised. A small two-state machine then latches a hard-trap output. Its states are ST_RUN, the normal state after reset, and ST_TRAP. The transition ST_RUN to ST_TRAP happens on any read that decodes as a double error. ST_TRAP only leaves on reset, and it returns to ST_RUN. Reads are still decoded while trapped. Errors are not counted and no syndrome is kept.

Top module: `secded_pair_guard`

## Requirements
- R1: `wr_check` is combinational from `wr_data`. Data bit i occupies codeword position p(i), the i-th integer of 3,5,6,7,9,... counting from zero, so that every power of two is skipped. Bit j (0..5) is the XOR of the data bits whose p(i) has bit j set. Bit 6 is the XOR of all 48 data bits and the bits 5..0.
- R2: `rd_word` is laid out as {check[6:0], data[47:0]}. The result of a read issued with `rd_valid` high appears on the next clock, with `rd_data_valid` high for exactly that one cycle.
- R3: A read of an unaltered codeword returns the stored data, and both `sbe_flag` and `ded_flag` are low.
- R4: A read with one flipped data bit (bit positions 0..47 of `rd_word`) returns the original data, with `sbe_flag` high and `ded_flag` low.
- R5: A read with one flipped check bit (bit positions 48..54 of `rd_word`) returns the data unchanged, with `sbe_flag` high and `ded_flag` low.
- R6: `sbe_irq` pulses together with `sbe_flag` only if `sbe_irq_en` was high in the read cycle. Otherwise it stays low.
- R7: A read with two flipped bits raises `ded_flag`, keeps `sbe_flag` low, and returns bits 47..0 of `rd_word` uncorrected.
- R8: `trap` rises in the same cycle as the first `ded_flag` and stays high until reset. Reads in ST_TRAP are still decoded normally.
- R9: During and directly after reset, `rd_data`, `rd_data_valid`, `sbe_flag`, `sbe_irq`, `ded_flag` and `trap` are all zero.
- R10: In a cycle without `rd_valid`, no flag is raised on the following cycle and `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_data | input | 48 | Instruction pair to be encoded |
| wr_check | output | 7 | Check code for `wr_data` |
| rd_valid | input | 1 | Read word presented this cycle |
| rd_word | input | 55 | Stored word {check, data} |
| sbe_irq_en | input | 1 | Enables forwarding of the single-error flag to `sbe_irq` |
| rd_data | output | 48 | Corrected (or passed-through) read data |
| rd_data_valid | output | 1 | `rd_data` holds a new read result |
| sbe_flag | output | 1 | One-cycle pulse: single error corrected |
| sbe_irq | output | 1 | One-cycle interrupt pulse for a single error |
| ded_flag | output | 1 | One-cycle pulse: uncorrectable double error |
| trap | output | 1 | Hard trap, held until reset |

## Verification
The checker tests on every cycle the relations among the read-side outputs. These are that a result appears exactly one cycle after a read, that the single and double flags never coincide, that the interrupt only follows an enabled single-error flag, that a double error is always accompanied by the trap and that the trap never drops, and that `rd_data` holds when no read was issued. The correctness of the code bits themselves, and the repair of every individual data and check bit position, can only be shown by the bench's scenarios. The bench builds codewords with its own position-based encoder, injects zero, one and two flips at chosen positions, and compares the outputs against its model on every clock. This includes reads made while trapped and the trap being cleared by reset.

// File: rtl/secded_pair_pkg.sv
package secded_pair_pkg;

    localparam int PAIR_W  = 48;
    localparam int HAM_W   = 6;
    localparam int CHECK_W = HAM_W + 1;
    localparam int WORD_W  = PAIR_W + CHECK_W;
    localparam int MAX_W   = 64;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_TRAP = 1'b1
    } guard_state_t;

    // Codeword position of data bit idx: idx-th integer >= 3 that is not a power of two.
    function automatic int pos_of(input int idx);
        int n;
        n = -1;
        for (int q = 3; q < 256; q++) begin
            if ((q & (q - 1)) != 0) begin
                n++;
                if (n == idx) return q;
            end
        end
        return 0;
    endfunction

    // Data bits that feed Hamming bit j.
    function automatic logic [MAX_W-1:0] col_mask(input int j, input int dw);
        logic [MAX_W-1:0] m;
        m = '0;
        for (int i = 0; i < dw; i++) begin
            m[i] = ((pos_of(i) >> j) & 1) != 0;
        end
        return m;
    endfunction

endpackage

// File: rtl/secded_pair_enc.sv
module secded_pair_enc
    import secded_pair_pkg::*;
#(
    parameter int DATA_W = PAIR_W,
    parameter int H_W    = HAM_W
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [H_W-1:0]    ham_o,
    output logic              all_par_o
);
    for (genvar j = 0; j < H_W; j++) begin : g_col
        localparam logic [MAX_W-1:0] FULL = col_mask(j, DATA_W);
        localparam logic [DATA_W-1:0] MASK = FULL[DATA_W-1:0];
        assign ham_o[j] = ^(data_i & MASK);
    end

    assign all_par_o = (^data_i) ^ (^ham_o);
endmodule

// File: rtl/secded_pair_dec.sv
module secded_pair_dec
    import secded_pair_pkg::*;
#(
    parameter int DATA_W = PAIR_W,
    parameter int H_W    = HAM_W
) (
    input  logic [DATA_W+H_W:0] word_i,
    output logic [DATA_W-1:0]   data_o,
    output logic                single_o,
    output logic                double_o
);
    localparam int            LAST_POS = DATA_W + H_W;
    localparam logic [H_W-1:0] TOP_POS = H_W'(LAST_POS);

    logic [DATA_W-1:0] data_raw;
    logic [H_W-1:0]    ham_stored;
    logic [H_W-1:0]    ham_recalc;
    logic [H_W-1:0]    syndrome;
    logic              unused_par;
    logic              parity_bad;
    logic              syn_in_range;

    assign data_raw   = word_i[DATA_W-1:0];
    assign ham_stored = word_i[DATA_W+H_W-1:DATA_W];

    secded_pair_enc #(.DATA_W(DATA_W), .H_W(H_W)) u_recalc (
        .data_i   (data_raw),
        .ham_o    (ham_recalc),
        .all_par_o(unused_par)
    );

    assign syndrome     = ham_recalc ^ ham_stored;
    assign parity_bad   = ^word_i;
    assign syn_in_range = (syndrome <= TOP_POS);

    assign single_o = parity_bad && syn_in_range;
    assign double_o = (!parity_bad && (syndrome != '0)) || (parity_bad && !syn_in_range);

    for (genvar i = 0; i < DATA_W; i++) begin : g_fix
        localparam logic [H_W-1:0] POS = H_W'(pos_of(i));
        assign data_o[i] = data_raw[i] ^ (single_o && (syndrome == POS));
    end
endmodule

// File: rtl/secded_pair_guard.sv
module secded_pair_guard
    import secded_pair_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PAIR_W-1:0]  wr_data,
    output logic [CHECK_W-1:0] wr_check,
    input  logic               rd_valid,
    input  logic [WORD_W-1:0]  rd_word,
    input  logic               sbe_irq_en,
    output logic [PAIR_W-1:0]  rd_data,
    output logic               rd_data_valid,
    output logic               sbe_flag,
    output logic               sbe_irq,
    output logic               ded_flag,
    output logic               trap
);
    guard_state_t        state_q, state_d;
    logic [HAM_W-1:0]    wr_ham;
    logic                wr_par;
    logic [PAIR_W-1:0]   dec_data;
    logic                dec_single;
    logic                dec_double;

    secded_pair_enc #(.DATA_W(PAIR_W), .H_W(HAM_W)) u_enc (
        .data_i   (wr_data),
        .ham_o    (wr_ham),
        .all_par_o(wr_par)
    );
    assign wr_check = {wr_par, wr_ham};

    secded_pair_dec #(.DATA_W(PAIR_W), .H_W(HAM_W)) u_dec (
        .word_i  (rd_word),
        .data_o  (dec_data),
        .single_o(dec_single),
        .double_o(dec_double)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (rd_valid && dec_double) state_d = ST_TRAP;
            ST_TRAP: state_d = ST_TRAP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        trap = (state_q == ST_TRAP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data       <= '0;
            rd_data_valid <= 1'b0;
            sbe_flag      <= 1'b0;
            sbe_irq       <= 1'b0;
            ded_flag      <= 1'b0;
        end else begin
            rd_data_valid <= rd_valid;
            sbe_flag      <= rd_valid && dec_single;
            sbe_irq       <= rd_valid && dec_single && sbe_irq_en;
            ded_flag      <= rd_valid && dec_double;
            if (rd_valid) rd_data <= dec_data;
        end
    end
endmodule

// File: rtl/secded_pair_guard_chk.sv
module secded_pair_guard_chk
    import secded_pair_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rd_valid,
    input logic              sbe_irq_en,
    input logic [PAIR_W-1:0] rd_data,
    input logic              rd_data_valid,
    input logic              sbe_flag,
    input logic              sbe_irq,
    input logic              ded_flag,
    input logic              trap
);
    AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |=> rd_data_valid); // R2
    AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n) !rd_valid |=> !rd_data_valid); // R2
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(sbe_flag && ded_flag)); // R7
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) sbe_irq |-> sbe_flag); // R6
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) sbe_irq |-> $past(sbe_irq_en)); // R6
    AST_FLAG_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n) (sbe_flag || ded_flag) |-> rd_data_valid); // R10
    AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !rd_valid |=> $stable(rd_data)); // R10
    AST_TRAP_WITH_DED: assert property (@(posedge clk) disable iff (!rst_n) ded_flag |-> trap); // R8
    AST_TRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n) trap |=> trap); // R8
endmodule

bind secded_pair_guard secded_pair_guard_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_valid     (rd_valid),
    .sbe_irq_en   (sbe_irq_en),
    .rd_data      (rd_data),
    .rd_data_valid(rd_data_valid),
    .sbe_flag     (sbe_flag),
    .sbe_irq      (sbe_irq),
    .ded_flag     (ded_flag),
    .trap         (trap)
);

// File: tb/secded_pair_guard_tb_top.sv
module secded_pair_guard_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] wr_data = '0;
    logic [6:0]  wr_check;
    logic        rd_valid = 1'b0;
    logic [54:0] rd_word = '0;
    logic        sbe_irq_en = 1'b0;
    logic [47:0] rd_data;
    logic        rd_data_valid, sbe_flag, sbe_irq, ded_flag, trap;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [47:0] m_data;
    logic        m_vld, m_sbe, m_irq, m_ded, m_trap;

    always #(CLK_PERIOD/2) clk = ~clk;

    secded_pair_guard dut_i (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_check(wr_check),
        .rd_valid(rd_valid), .rd_word(rd_word), .sbe_irq_en(sbe_irq_en),
        .rd_data(rd_data), .rd_data_valid(rd_data_valid), .sbe_flag(sbe_flag),
        .sbe_irq(sbe_irq), .ded_flag(ded_flag), .trap(trap)
    );

    // Position-based reference encoder.
    function automatic logic [6:0] ref_code(input logic [47:0] d);
        bit cw[64];
        int k;
        logic [6:0] c;
        k = 0;
        for (int p = 1; p <= 54; p++) begin
            if ((p & (p - 1)) == 0) cw[p] = 1'b0;
            else begin cw[p] = d[k]; k++; end
        end
        for (int j = 0; j < 6; j++) begin
            c[j] = 1'b0;
            for (int p = 1; p <= 54; p++) if (((p >> j) & 1) != 0) c[j] ^= cw[p];
        end
        c[6] = (^d) ^ (^c[5:0]);
        return c;
    endfunction

    task automatic cmp(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cmp_all(input string req);
        cmp(req, "rd_data", 64'(rd_data), 64'(m_data));
        cmp("R2", "rd_data_valid", 64'(rd_data_valid), 64'(m_vld));
        cmp(req, "sbe_flag", 64'(sbe_flag), 64'(m_sbe));
        cmp("R6", "sbe_irq", 64'(sbe_irq), 64'(m_irq));
        cmp(req, "ded_flag", 64'(ded_flag), 64'(m_ded));
        cmp("R8", "trap", 64'(trap), 64'(m_trap));
    endtask

    task automatic model_reset();
        m_data = '0; m_vld = 0; m_sbe = 0; m_irq = 0; m_ded = 0; m_trap = 0;
    endtask

    // One cycle: drive at negedge, check encoder, advance model, compare at next negedge.
    // nflip: 0..2 flipped positions b0/b1 in the 55-bit word; nflip<0 means idle.
    task automatic cyc(input string req, input logic [47:0] d, input int nflip,
                       input int b0, input int b1, input bit en);
        logic [54:0] w;
        logic [6:0]  c;
        c = ref_code(d);
        w = {c, d};
        if (nflip >= 1) w[b0] = ~w[b0];
        if (nflip >= 2) w[b1] = ~w[b1];
        wr_data    = d;
        rd_word    = w;
        rd_valid   = (nflip >= 0);
        sbe_irq_en = en;
        #1;
        cmp("R1", "wr_check", 64'(wr_check), 64'(c));
        m_vld = (nflip >= 0);
        m_sbe = (nflip == 1);
        m_irq = (nflip == 1) && en;
        m_ded = (nflip == 2);
        if (nflip == 2) begin m_data = w[47:0]; m_trap = 1'b1; end
        else if (nflip >= 0) m_data = d;
        @(negedge clk);
        cmp_all(req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rd_valid = 1'b0;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        cmp_all("R9");
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [47:0] d;
        void'($urandom(32'h5eed));
        @(negedge clk);
        do_reset();                                   // R9
        cyc("R10", 48'h0, -1, 0, 0, 1'b0);            // R10 idle after reset
        cyc("R1", 48'hFFFF_FFFF_FFFF, -1, 0, 0, 1'b0);
        for (int i = 0; i < 48; i++) cyc("R10", 48'(1) << i, -1, 0, 0, 1'b1); // R1 walking ones, R10 no read
        cyc("R3", 48'h0, 0, 0, 0, 1'b1);
        cyc("R3", 48'hFFFF_FFFF_FFFF, 0, 0, 0, 1'b1);
        for (int i = 0; i < 20; i++) cyc("R3", {$urandom, $urandom}, 0, 0, 0, 1'b1); // R3
        for (int i = 0; i < 48; i++) cyc("R4", {$urandom, $urandom}, 1, i, 0, i[0]); // R4, R6
        for (int i = 48; i < 55; i++) cyc("R5", {$urandom, $urandom}, 1, i, 0, 1'b1); // R5
        cyc("R6", 48'h1234_5678_9ABC, 1, 5, 0, 1'b0); // R6 disabled
        d = 48'hA5A5_5A5A_F00F;
        cyc("R2", d, 0, 0, 0, 1'b0);
        cyc("R10", 48'h0, -1, 0, 0, 1'b1);           // R10 data held, no flags
        cyc("R10", 48'h0, -1, 0, 0, 1'b1);
        cyc("R7", 48'hDEAD_BEEF_0001, 2, 3, 40, 1'b1); // R7 first double: trap rises (R8)
        for (int i = 0; i < 10; i++) begin
            int a, b;
            a = $urandom_range(0, 54);
            b = (a + 1 + $urandom_range(0, 53)) % 55;
            cyc("R7", {$urandom, $urandom}, 2, a, b, 1'b1);
        end
        for (int i = 0; i < 5; i++) cyc("R8", {$urandom, $urandom}, 0, 0, 0, 1'b1); // R8 decoding in trap
        cyc("R8", 48'h0F0F_0F0F_0F0F, 1, 17, 0, 1'b1);
        cyc("R8", 48'h0, -1, 0, 0, 1'b0);
        do_reset();                                   // R8 trap cleared, R9
        cyc("R3", 48'h1357_9BDF_2468, 0, 0, 0, 1'b0);
        cyc("R4", 48'h1357_9BDF_2468, 1, 47, 0, 1'b1);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule